// File: doc/BRIEF.md
# Block-Transfer SPI Master with Word FIFO

This engine is a SPI master that moves a programmed number of bytes between a 32-bit word FIFO and one of several attached devices. Each transfer goes in one direction only. Software uses a small register port. It first writes a control word that sets the serial clock rate, the target device, the lane width (one data line or four) and the direction. It then writes the byte count and sets the start bit. During the transfer it keeps the FIFO fed, or drains it, guided by a single status bit.

Bytes are packed into FIFO words little-endian. A transfer whose length is not a multiple of four uses only the low bytes of its last word. In four-lane mode each serial clock carries one nibble, high nibble first. The busy flag drops as soon as the last byte has been shifted. The device stays selected after that, so software can chain a command phase and a data phase under one chip select. The select is released only when software writes zero to the select register.

Top module: `sbx_engine`

## Requirements
- R1: After reset every chip-select line is high, the serial clock is low, and the control, select and length registers read 0.
- R2: Control bits 2:0 (rate) set each serial clock phase, high and low, to 2^rate system cycles. Control bits 7:6 (device) pick the chip-select line driven low during a transfer, and only that line.
- R3: The length register keeps bits 20:0 of a write and reads its unused upper bits as 0.
- R4: In single-lane write mode (bit 12 = 0, bit 13 = 1) each byte leaves on io_out[0], MSB first, over 8 serial clocks. The device samples on the rising edge.
- R5: In four-lane write mode (bit 12 = 1, bit 13 = 1) each byte leaves on io_out[3:0], high nibble first, over 2 serial clocks.
- R6: In read mode (bit 13 = 0) the engine samples io_in[1] per clock in single-lane mode, or io_in[3:0] per clock in four-lane mode, on the rising edge. In four-lane read mode no output enable is asserted.
- R7: Transfer byte n sits in FIFO-word bits 8*(n mod 4)+7 : 8*(n mod 4). Unused bytes of a received final word read 0, and unused bytes of a transmitted final word are never sent.
- R8: Status bit 0 reads 1 when the FIFO is full in write mode, or empty in read mode. Software pushes or pops only while it reads 0.
- R9: Writing 1 to control bit 15 while idle starts a transfer. Bit 15 reads 1 until the last byte has been shifted and then clears, while chip select stays low and select bit 0 reads 1.
- R10: Writing 0 to select bit 0 while idle raises all chip-select lines. Writing 1 to it, or any write while busy, leaves the select unchanged.
- R11: Writes to the control or length register during a transfer have no effect.
- R12: The serial clock toggles only while a transfer is busy, and exactly 8 (single-lane) or 2 (four-lane) rising edges occur per byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO on the data address) |
| reg_addr | input | 3 | Word address: 0 control, 1 select, 2 length, 3 FIFO, 4 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, valid in the same cycle |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | NUM_CS | Active-low device selects |
| spi_io_out | output | 4 | Data lanes driven to the device |
| spi_io_oe | output | 4 | Output enable per lane |
| spi_io_in | input | 4 | Data lanes from the device |

## Verification
A byte counter that slips, or a lane pointer that is off by one, shows at the ports within one transfer. The rising-edge count differs from 8 or 2 per byte, or a FIFO word comes back with its bytes rotated. A stuck busy state shows either as a serial clock still toggling after busy drops or as the control poll never clearing, which the watchdog catches. A wrong select state shows at once on the chip-select lines: a second line going low, or a release that happens without the zero write to the select register.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
    localparam int LEN_W  = 21;
    localparam int CLK_W  = 3;
    localparam int DEV_W  = 2;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_SEL  = 3'd1;
    localparam logic [ADDR_W-1:0] A_LEN  = 3'd2;
    localparam logic [ADDR_W-1:0] A_FIFO = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

    localparam int B_DEV  = 6;
    localparam int B_QUAD = 12;
    localparam int B_DIR  = 13;
    localparam int B_GO   = 15;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SHIFT
    } eng_st_e;
endpackage

// File: rtl/sbx_fifo.sv
module sbx_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          full,
    output logic          empty
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW:0] wp;
        logic [AW:0] rp;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [DW-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full    = (ptr_q.wp ^ ptr_q.rp) == {1'b1, {AW{1'b0}}};
    assign empty   = ptr_q.wp == ptr_q.rp;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[ptr_q.rp[AW-1:0]];

    always_comb begin
        ptr_d = ptr_q;
        if (do_push) ptr_d.wp = ptr_q.wp + 1'b1;
        if (do_pop)  ptr_d.rp = ptr_q.rp + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[ptr_q.wp[AW-1:0]] <= wdata;
    end
endmodule

// File: rtl/sbx_shifter.sv
module sbx_shifter #(
    parameter int CLK_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       tx_byte,
    input  logic             quad,
    input  logic             wr_dir,
    input  logic [CLK_W-1:0] rate,
    input  logic [3:0]       io_in,
    output logic             sck,
    output logic [3:0]       io_out,
    output logic [3:0]       io_oe,
    output logic [7:0]       rx_byte,
    output logic             done
);
    localparam int DIV_W = 1 << CLK_W;

    typedef struct packed {
        logic             active;
        logic             sck;
        logic             done;
        logic [DIV_W-1:0] div;
        logic [2:0]       step;
        logic [7:0]       sr;
        logic [7:0]       rx;
    } sh_t;

    sh_t sh_d, sh_q;
    logic [DIV_W-1:0] half_m1;
    logic [2:0]       last_step;

    assign half_m1   = (DIV_W'(1) << rate) - DIV_W'(1);
    assign last_step = quad ? 3'd1 : 3'd7;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        if (!sh_q.active) begin
            if (start) begin
                sh_d.active = 1'b1;
                sh_d.sck    = 1'b0;
                sh_d.div    = '0;
                sh_d.step   = '0;
                sh_d.sr     = tx_byte;
                sh_d.rx     = '0;
            end
        end else if (sh_q.div == half_m1) begin
            sh_d.div = '0;
            if (!sh_q.sck) begin
                sh_d.sck = 1'b1;
                sh_d.rx  = quad ? {sh_q.rx[3:0], io_in} : {sh_q.rx[6:0], io_in[1]};
            end else begin
                sh_d.sck = 1'b0;
                if (sh_q.step == last_step) begin
                    sh_d.active = 1'b0;
                    sh_d.done   = 1'b1;
                end else begin
                    sh_d.step = sh_q.step + 3'd1;
                    sh_d.sr   = quad ? {sh_q.sr[3:0], 4'b0} : {sh_q.sr[6:0], 1'b0};
                end
            end
        end else begin
            sh_d.div = sh_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    always_comb begin
        io_out = 4'b0;
        io_oe  = 4'b0;
        if (sh_q.active) begin
            if (wr_dir) begin
                io_out = quad ? sh_q.sr[7:4] : {3'b0, sh_q.sr[7]};
                io_oe  = quad ? 4'b1111 : 4'b0001;
            end else begin
                io_oe  = quad ? 4'b0000 : 4'b0001;
            end
        end
    end

    assign sck     = sh_q.sck;
    assign rx_byte = sh_q.rx;
    assign done    = sh_q.done;
endmodule

// File: rtl/sbx_engine.sv
module sbx_engine
    import sbx_pkg::*;
#(
    parameter int NUM_CS      = 4,
    parameter int FIFO_DEPTH  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                spi_sck,
    output logic [NUM_CS-1:0]   spi_cs_n,
    output logic [3:0]          spi_io_out,
    output logic [3:0]          spi_io_oe,
    input  logic [3:0]          spi_io_in
);
    typedef struct packed {
        eng_st_e          st;
        logic [CLK_W-1:0] rate;
        logic [DEV_W-1:0] dev;
        logic             quad;
        logic             wr_dir;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] remain;
        logic [1:0]       lane;
        logic [31:0]      pack;
        logic             cs_act;
    } eng_t;

    eng_t e_d, e_q;

    logic             busy, cs_act, quad_cfg, wr_cfg;
    logic [LEN_W-1:0] remain;
    logic             ctrl_wr, sel_wr, len_wr;
    logic             sw_push, sw_pop, eng_push, eng_pop;
    logic [31:0]      eng_wdata, fifo_wdata, fifo_head, lane_word;
    logic             fifo_full, fifo_empty, fifo_busy;
    logic             sh_start, sh_done;
    logic [7:0]       tx_byte, rx_byte;
    logic             last_in_word;

    assign busy     = e_q.st != ST_IDLE;
    assign cs_act   = e_q.cs_act;
    assign quad_cfg = e_q.quad;
    assign wr_cfg   = e_q.wr_dir;
    assign remain   = e_q.remain;

    assign ctrl_wr = reg_wr && reg_addr == A_CTRL;
    assign sel_wr  = reg_wr && reg_addr == A_SEL;
    assign len_wr  = reg_wr && reg_addr == A_LEN;
    assign sw_push = reg_wr && reg_addr == A_FIFO && e_q.wr_dir;
    assign sw_pop  = reg_rd && reg_addr == A_FIFO && !e_q.wr_dir;

    assign last_in_word = (e_q.lane == 2'd3) || (e_q.remain == LEN_W'(1));
    assign lane_word    = fifo_head >> {e_q.lane, 3'b000};
    assign fifo_busy    = e_q.wr_dir ? fifo_full : fifo_empty;

    always_comb begin
        e_d       = e_q;
        sh_start  = 1'b0;
        tx_byte   = 8'h00;
        eng_pop   = 1'b0;
        eng_push  = 1'b0;
        eng_wdata = 32'h0;
        unique case (e_q.st)
            ST_IDLE: begin
                if (ctrl_wr) begin
                    e_d.rate   = reg_wdata[CLK_W-1:0];
                    e_d.dev    = reg_wdata[B_DEV +: DEV_W];
                    e_d.quad   = reg_wdata[B_QUAD];
                    e_d.wr_dir = reg_wdata[B_DIR];
                    if (reg_wdata[B_GO]) begin
                        e_d.st     = ST_FETCH;
                        e_d.remain = e_q.len;
                        e_d.lane   = 2'd0;
                        e_d.pack   = 32'h0;
                        e_d.cs_act = 1'b1;
                    end
                end
                if (len_wr) e_d.len = reg_wdata[LEN_W-1:0];
                if (sel_wr && !reg_wdata[0]) e_d.cs_act = 1'b0;
            end
            ST_FETCH: begin
                if (e_q.remain == '0) begin
                    e_d.st = ST_IDLE;
                end else if (e_q.wr_dir) begin
                    if (!fifo_empty) begin
                        sh_start = 1'b1;
                        tx_byte  = lane_word[7:0];
                        eng_pop  = last_in_word;
                        e_d.st   = ST_SHIFT;
                    end
                end else if (!fifo_full) begin
                    sh_start = 1'b1;
                    e_d.st   = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (sh_done) begin
                    if (!e_q.wr_dir) begin
                        eng_wdata = e_q.pack | ({24'h0, rx_byte} << {e_q.lane, 3'b000});
                        if (last_in_word) begin
                            eng_push = 1'b1;
                            e_d.pack = 32'h0;
                        end else begin
                            e_d.pack = eng_wdata;
                        end
                    end
                    e_d.remain = e_q.remain - LEN_W'(1);
                    e_d.lane   = e_q.lane + 2'd1;
                    e_d.st     = ST_FETCH;
                end
            end
            default: e_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q    <= '0;
            e_q.st <= ST_IDLE;
        end else begin
            e_q <= e_d;
        end
    end

    assign fifo_wdata = e_q.wr_dir ? reg_wdata : eng_wdata;

    sbx_fifo #(
        .DW    (32),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (sw_push || eng_push),
        .wdata (fifo_wdata),
        .pop   (sw_pop || eng_pop),
        .head  (fifo_head),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    sbx_shifter #(
        .CLK_W (CLK_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (tx_byte),
        .quad    (e_q.quad),
        .wr_dir  (e_q.wr_dir),
        .rate    (e_q.rate),
        .io_in   (spi_io_in),
        .sck     (spi_sck),
        .io_out  (spi_io_out),
        .io_oe   (spi_io_oe),
        .rx_byte (rx_byte),
        .done    (sh_done)
    );

    for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs
        assign spi_cs_n[gi] = !(e_q.cs_act && e_q.dev == DEV_W'(gi));
    end

    always_comb begin
        reg_rdata = 32'h0;
        unique case (reg_addr)
            A_CTRL: reg_rdata = {16'h0, busy, 1'b0, e_q.wr_dir, e_q.quad, 4'h0,
                                 e_q.dev, 3'b000, e_q.rate};
            A_SEL:  reg_rdata = {31'h0, e_q.cs_act};
            A_LEN:  reg_rdata = {{(32-LEN_W){1'b0}}, e_q.len};
            A_FIFO: reg_rdata = e_q.wr_dir ? 32'h0 : fifo_head;
            A_STAT: reg_rdata = {31'h0, fifo_busy};
            default: reg_rdata = 32'h0;
        endcase
    end
endmodule

// File: rtl/sbx_chk.sv
module sbx_chk #(
    parameter int NUM_CS = 4,
    parameter int LEN_W  = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sck,
    input logic [NUM_CS-1:0] cs_n,
    input logic [3:0]        io_oe,
    input logic              busy,
    input logic              cs_act,
    input logic              quad_cfg,
    input logic              wr_cfg,
    input logic [LEN_W-1:0]  remain,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic              wbit0
);
    // R12
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    // R2
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R9
    cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> cs_act);

    // R10
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_act) |-> $past(reg_wr && reg_addr == 3'd1 && !wbit0 && !busy));

    // R11
    remain_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> remain <= $past(remain));

    // R6
    quad_read_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && quad_cfg && !wr_cfg) |-> io_oe == 4'b0000);

    // R9
    busy_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> cs_act);
endmodule

bind sbx_engine sbx_chk #(
    .NUM_CS (NUM_CS),
    .LEN_W  (sbx_pkg::LEN_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (spi_sck),
    .cs_n     (spi_cs_n),
    .io_oe    (spi_io_oe),
    .busy     (busy),
    .cs_act   (cs_act),
    .quad_cfg (quad_cfg),
    .wr_cfg   (wr_cfg),
    .remain   (remain),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .wbit0    (reg_wdata[0])
);

// File: tb/tb_sbx_engine.sv
`timescale 1ns/1ps
module tb_sbx_engine;
    localparam int NUM_CS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        spi_sck;
    logic [NUM_CS-1:0] spi_cs_n;
    logic [3:0]  spi_io_out, spi_io_oe, spi_io_in;

    int tests = 0, fails = 0;

    always #5 clk = ~clk;

    sbx_engine #(.NUM_CS(NUM_CS), .FIFO_DEPTH(8)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_io_out(spi_io_out),
        .spi_io_oe(spi_io_oe), .spi_io_in(spi_io_in)
    );

    typedef struct packed {
        logic [7:0] len;
        logic [2:0] rate;
        logic [1:0] dev;
        logic       quad;
        logic       wr;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'd4,  3'd0, 2'd0, 1'b0, 1'b1},
        '{8'd7,  3'd1, 2'd1, 1'b1, 1'b1},
        '{8'd40, 3'd0, 2'd2, 1'b1, 1'b1},
        '{8'd5,  3'd0, 2'd3, 1'b0, 1'b0},
        '{8'd6,  3'd2, 2'd1, 1'b1, 1'b0},
        '{8'd37, 3'd0, 2'd0, 1'b1, 1'b0},
        '{8'd1,  3'd0, 2'd2, 1'b0, 1'b1},
        '{8'd3,  3'd3, 2'd0, 1'b0, 1'b0}
    };

    // device model state
    int         m_vec = 0;
    logic       m_quad = 1'b0, m_wr = 1'b0;
    int         bitk = 0, edges = 0;
    logic [7:0] cap [64];
    logic [7:0] shv = 8'h0;
    logic       first = 1'b0;
    time        t_rise = 0, width = 0;
    int         oe_bad = 0;

    function automatic logic [7:0] pat(input int v, input int k);
        return 8'(k * 37 + v * 11 + 5);
    endfunction

    function automatic logic [3:0] dev_drive(input int v, input int k, input logic q);
        logic [7:0] b;
        if (q) begin
            b = pat(v, k >> 1);
            return (k % 2 == 0) ? b[7:4] : b[3:0];
        end
        b = pat(v, k >> 3);
        return {2'b00, b[7 - (k % 8)], 1'b0};
    endfunction

    assign spi_io_in = m_wr ? 4'h0 : dev_drive(m_vec, bitk, m_quad);

    always @(posedge spi_sck) begin
        edges <= edges + 1;
        if (first) t_rise = $time;
        if (m_quad && !m_wr && spi_io_oe != 4'h0) oe_bad <= oe_bad + 1;
        if (m_wr) begin
            if (m_quad) begin
                shv = {shv[3:0], spi_io_out};
                if (bitk % 2 == 1) cap[(bitk >> 1) % 64] = shv;
            end else begin
                shv = {shv[6:0], spi_io_out[0]};
                if (bitk % 8 == 7) cap[(bitk >> 3) % 64] = shv;
            end
        end
        bitk <= bitk + 1;
    end

    always @(negedge spi_sck) begin
        if (first) begin
            width = $time - t_rise;
            first = 1'b0;
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] r;
        do reg_read(3'd0, r); while (r[15]);
    endtask

    function automatic logic [31:0] word_of(input int v, input int w, input int len,
                                            input logic [7:0] fill);
        logic [31:0] x;
        for (int j = 0; j < 4; j++)
            x[8*j +: 8] = (4*w + j < len) ? pat(v, 4*w + j) : fill;
        return x;
    endfunction

    task automatic run_vec(input int v);
        vec_t c;
        logic [31:0] ctl, st, w, r;
        int words, idx, bad, per;
        c = VECS[v];
        ctl = {16'h0, 1'b0, 1'b0, c.wr, c.quad, 4'h0, c.dev, 3'b000, c.rate};
        reg_write(3'd0, ctl);
        reg_write(3'd2, 32'(c.len));
        m_vec = v; m_quad = c.quad; m_wr = c.wr;
        bitk = 0; edges = 0; first = 1'b1; width = 0; oe_bad = 0;
        reg_write(3'd0, ctl | 32'h8000);
        words = (int'(c.len) + 3) / 4; idx = 0; bad = 0;
        while (idx < words) begin
            reg_read(3'd4, st);
            if (!st[0]) begin
                if (c.wr) begin
                    reg_write(3'd3, word_of(v, idx, c.len, 8'hEE));
                end else begin
                    reg_read(3'd3, w);
                    // R7: little-endian packing, zero upper bytes in final word
                    if (w != word_of(v, idx, c.len, 8'h00)) bad++;
                end
                idx++;
            end
        end
        wait_idle();
        if (c.wr) begin
            for (int k = 0; k < int'(c.len); k++) if (cap[k] != pat(v, k)) bad++;
            check(bad == 0, c.quad ? "R5 quad write bytes" : "R4 single write bytes",
                  32'(bad), 0);
        end else begin
            check(bad == 0, "R7 R6 read packing", 32'(bad), 0);
        end
        per = c.quad ? 2 : 8;
        check(edges == int'(c.len) * per, "R12 rising edges per byte", 32'(edges),
              32'(int'(c.len) * per));
        check(width == time'(10 * (1 << c.rate)), "R2 clock phase width",
              32'(width), 32'(10 * (1 << c.rate)));
        if (c.quad && !c.wr) check(oe_bad == 0, "R6 no drive in quad read", 32'(oe_bad), 0);
        reg_read(3'd1, r);
        check(r == 32'h1 && spi_cs_n == ~(4'b0001 << c.dev),
              "R9 select held after busy clears", {27'h0, spi_cs_n, r[0]},
              {27'h0, ~(4'b0001 << c.dev), 1'b1});
        reg_write(3'd1, 32'h0);
        check(spi_cs_n == '1, "R10 release by zero write", 32'(spi_cs_n), 32'hF);
    endtask

    task automatic run_all();
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(spi_cs_n == '1 && spi_sck == 1'b0, "R1 pins after reset",
              {27'h0, spi_cs_n, spi_sck}, {27'h0, 4'hF, 1'b0});
        reg_read(3'd0, r); check(r == 0, "R1 control reset", r, 0);
        reg_read(3'd1, r); check(r == 0, "R1 select reset", r, 0);
        reg_read(3'd2, r); check(r == 0, "R1 length reset", r, 0);
        // R8 read direction with empty FIFO reports busy
        reg_read(3'd4, r); check(r == 1, "R8 empty in read mode", r, 1);
        // R3 length masking
        reg_write(3'd2, 32'hFFFF_FFFF);
        reg_read(3'd2, r); check(r == 32'h001F_FFFF, "R3 length width", r, 32'h001F_FFFF);

        // table-driven transfers
        for (int v = 0; v < NV; v++) run_vec(v);

        // R8 full in write mode, then R11 and R10 while busy
        reg_write(3'd0, 32'h0000_2040);
        reg_write(3'd2, 32'd32);
        for (int k = 0; k < 8; k++) begin
            reg_read(3'd4, r);
            if (k == 0) check(r == 0, "R8 not full in write mode", r, 0);
            reg_write(3'd3, 32'h1111_1111 * (k + 1));
        end
        reg_read(3'd4, r); check(r == 1, "R8 full in write mode", r, 1);
        m_vec = 0; m_quad = 1'b0; m_wr = 1'b1; bitk = 0; edges = 0; first = 1'b0;
        reg_write(3'd0, 32'h0000_A040);
        reg_write(3'd0, 32'h0000_B083);
        reg_read(3'd0, r);
        check(r == 32'h0000_A040, "R11 control ignored while busy", r, 32'h0000_A040);
        reg_write(3'd2, 32'd5);
        reg_read(3'd2, r); check(r == 32'd32, "R11 length ignored while busy", r, 32);
        reg_write(3'd1, 32'h0);
        check(spi_cs_n == 4'b1101, "R10 release ignored while busy", 32'(spi_cs_n), 32'hD);
        wait_idle();
        check(edges == 256, "R12 edge count after busy-time writes", 32'(edges), 256);
        reg_write(3'd1, 32'h1);
        check(spi_cs_n == 4'b1101, "R10 write of one keeps select", 32'(spi_cs_n), 32'hD);
        reg_write(3'd1, 32'h0);
        reg_read(3'd1, r);
        check(r == 0 && spi_cs_n == '1, "R10 select released", {27'h0, spi_cs_n, r[0]},
              {27'h0, 4'hF, 1'b0});
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                tests++; fails++;
                $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule